// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in eight byte-wide registers, all in binary coded decimal. It advances once per second. A free-running strobe, `subTick`, arrives several times per second from a prescaler outside the block. An internal divider turns `TICKS_PER_SEC` of those strobes into one second step.

Seconds, minutes, hours, date, month, day of week and year form a carry chain. The date wraps according to the length of the current month, with leap Februaries in years divisible by four. The hour register holds either a 24-hour value or a 12-hour value with an AM/PM flag.

A serial front end, which sits outside this block, issues single-cycle writes through `wrEn`/`wrAddr`/`wrData`. Any reader sees every register through a combinational read port. A protect bit in the control register locks the time and calendar registers against writes.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hour 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01, year 0x00 and control 0x00.
- R2: Registers sit at these addresses: seconds 0, minutes 1, hour 2, date 3, month 4, day of week 5, year 6, control 7. `rdData` shows the register selected by `rdAddr` in the same cycle. On a write, bits outside each register's field are dropped and read as 0. The masks are seconds 0x7F, minutes 0x7F, hour 0xBF, date 0x3F, month 0x1F, day of week 0x07, year 0xFF and control 0x80.
- R3: Each second step increments the seconds register in BCD. Seconds 59 wraps to 00 and steps the minutes. Minutes 59 wraps to 00 and steps the hour. In 24-hour mode (hour bit 7 = 0), hour 23 wraps to 00 and steps the date.
- R4: Hour bit 7 = 1 selects 12-hour mode, with bit 5 as the PM flag and bits 4:0 counting 12, 01 … 11 in BCD. The step from 11 to 12 inverts the PM flag. The step from 11 PM to 12 AM also steps the date. For example, 0x91 steps to 0xB2, 0xB1 steps to 0x92, and 0x92 steps to 0x81.
- R5: When control bit 7 (write protect) is 1, writes to addresses 0 to 6 leave those registers unchanged. The control register stays writable at all times.
- R6: The date wraps to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In month 2 it wraps after 29 when the year value is divisible by 4, and after 28 otherwise. Each wrap steps the month.
- R7: Month 12 wraps to 01 and steps the year. Year 99 wraps to 00.
- R8: Day of week steps whenever the date steps, counting 1 to 7 and wrapping from 7 to 1.
- R9: A second step occurs on every `TICKS_PER_SEC`-th `subTick`. An accepted write to the seconds register resets the divider, so the next step needs a further `TICKS_PER_SEC` strobes.
- R10: A write in the same cycle as a second step loads the written register with the written value. The step still advances the other registers, and a write to any register other than seconds does not disturb the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | Sub-second strobe from the external prescaler |
| wrEn | input | 1 | Single-cycle write request |
| wrAddr | input | 3 | Register address of the write |
| wrData | input | 8 | BCD value to write |
| rdAddr | input | 3 | Register address to read |
| rdData | output | 8 | Contents of the addressed register |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 3. With so short a divider, a single second step costs only three strobes. That makes partial divider counts and the clearing effect of a seconds write cheap to observe from both sides of the boundary. Every carry case is set up by preloading the registers just below their wrap points, so one second step exercises the full chain from seconds up to the year. This covers leap and common Februaries, 30-day months and both hour modes without simulating long stretches of time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_NUM = 8;
  localparam int ADDR_W  = $clog2(REG_NUM);
  localparam int DATA_W  = 8;

  localparam int A_SEC   = 0;
  localparam int A_MIN   = 1;
  localparam int A_HOUR  = 2;
  localparam int A_DATE  = 3;
  localparam int A_MONTH = 4;
  localparam int A_DOW   = 5;
  localparam int A_YEAR  = 6;
  localparam int A_CTRL  = 7;

  typedef struct packed {
    logic                secTick;
    logic [REG_NUM-1:0]  wrSel;
    logic [DATA_W-1:0]   wrVal;
  } rtcStrobe_t;

  function automatic logic [DATA_W-1:0] regMask(input int idx);
    case (idx)
      A_SEC, A_MIN: return 8'h7F;
      A_HOUR:       return 8'hBF;
      A_DATE:       return 8'h3F;
      A_MONTH:      return 8'h1F;
      A_DOW:        return 8'h07;
      A_YEAR:       return 8'hFF;
      default:      return 8'h80;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] monthLen(input logic [7:0] month, input logic [7:0] year);
    logic [1:0] mod4;
    mod4 = {year[4], 1'b0} + year[1:0];
    case (month)
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      8'h02:                      return (mod4 == 2'd0) ? 8'h29 : 8'h28;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              subTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wpBit,
  output rtcStrobe_t        stb
);
  localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0]   subCnt;
  logic [REG_NUM-1:0] selVec;
  logic               secWrite;
  logic               secTick;

  for (genvar i = 0; i < REG_NUM; i++) begin : g_sel
    if (i == A_CTRL) begin : g_open
      assign selVec[i] = wrEn && (wrAddr == ADDR_W'(i));
    end else begin : g_guard
      assign selVec[i] = wrEn && (wrAddr == ADDR_W'(i)) && !wpBit;
    end
  end

  assign secWrite = selVec[A_SEC];
  assign secTick  = subTick && (subCnt == LAST) && !secWrite;

  always_ff @(posedge clk) begin
    if (!rst_n)        subCnt <= '0;
    else if (secWrite) subCnt <= '0;
    else if (subTick)  subCnt <= (subCnt == LAST) ? '0 : subCnt + 1'b1;
  end

  always_comb begin
    stb.secTick = secTick;
    stb.wrSel   = selVec;
    stb.wrVal   = wrData;
  end

  a_r9_sub_clear: assert property (@(posedge clk) disable iff (!rst_n)
    secWrite |=> (subCnt == '0));

  if (TICKS_PER_SEC > 1) begin : g_spacing
    a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      secTick |=> !secTick);
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rtcStrobe_t        stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wpBit
);
  logic [DATA_W-1:0] regQ   [REG_NUM];
  logic [DATA_W-1:0] regNxt [REG_NUM];
  logic [REG_NUM-1:0] adv;

  logic [7:0] secR, minR, hourR, dateR, monR, dowR, yearR;
  logic       hourCarry;
  logic [7:0] inc24, inc12;

  assign secR  = regQ[A_SEC];
  assign minR  = regQ[A_MIN];
  assign hourR = regQ[A_HOUR];
  assign dateR = regQ[A_DATE];
  assign monR  = regQ[A_MONTH];
  assign dowR  = regQ[A_DOW];
  assign yearR = regQ[A_YEAR];
  assign wpBit = regQ[A_CTRL][7];

  assign inc24 = bcdInc({2'b00, hourR[5:0]});
  assign inc12 = bcdInc({3'b000, hourR[4:0]});

  always_comb begin
    if (!hourR[7]) begin
      hourCarry        = (hourR[5:0] == 6'h23);
      regNxt[A_HOUR]   = hourCarry ? 8'h00 : {2'b00, inc24[5:0]};
    end else if (hourR[4:0] == 5'h12) begin
      hourCarry        = 1'b0;
      regNxt[A_HOUR]   = {2'b10, hourR[5], 5'h01};
    end else if (hourR[4:0] == 5'h11) begin
      hourCarry        = hourR[5];
      regNxt[A_HOUR]   = {2'b10, ~hourR[5], 5'h12};
    end else begin
      hourCarry        = 1'b0;
      regNxt[A_HOUR]   = {2'b10, hourR[5], inc12[4:0]};
    end
  end

  always_comb begin
    regNxt[A_SEC]   = (secR == 8'h59) ? 8'h00 : bcdInc(secR);
    regNxt[A_MIN]   = (minR == 8'h59) ? 8'h00 : bcdInc(minR);
    regNxt[A_DATE]  = (dateR == monthLen(monR, yearR)) ? 8'h01 : bcdInc(dateR);
    regNxt[A_MONTH] = (monR == 8'h12) ? 8'h01 : bcdInc(monR);
    regNxt[A_DOW]   = (dowR == 8'h07) ? 8'h01 : dowR + 8'd1;
    regNxt[A_YEAR]  = (yearR == 8'h99) ? 8'h00 : bcdInc(yearR);
    regNxt[A_CTRL]  = regQ[A_CTRL];
  end

  always_comb begin
    adv[A_SEC]   = stb.secTick;
    adv[A_MIN]   = adv[A_SEC] && (secR == 8'h59);
    adv[A_HOUR]  = adv[A_MIN] && (minR == 8'h59);
    adv[A_DATE]  = adv[A_HOUR] && hourCarry;
    adv[A_DOW]   = adv[A_DATE];
    adv[A_MONTH] = adv[A_DATE] && (dateR == monthLen(monR, yearR));
    adv[A_YEAR]  = adv[A_MONTH] && (monR == 8'h12);
    adv[A_CTRL]  = 1'b0;
  end

  for (genvar i = 0; i < REG_NUM; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == A_DATE || i == A_MONTH || i == A_DOW) ? 8'h01 : 8'h00;
    always_ff @(posedge clk) begin
      if (!rst_n)             regQ[i] <= RST_VAL;
      else if (stb.wrSel[i])  regQ[i] <= stb.wrVal & regMask(i);
      else if (adv[i])        regQ[i] <= regNxt[i];
    end
  end

  assign rdData = regQ[rdAddr];

  a_r5_wp_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wpBit |-> (stb.wrSel[REG_NUM-2:0] == '0));

  a_r3_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.secTick && !stb.wrSel[A_SEC]) |=> $stable(regQ[A_SEC]));

  a_r7_year_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.secTick && !stb.wrSel[A_YEAR]) |=> $stable(regQ[A_YEAR]));

  a_r8_dow_follows_date: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.wrSel[A_DATE] && !stb.wrSel[A_DOW] && !adv[A_DATE]) |=> $stable(regQ[A_DOW]));
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       subTick,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);
  rtcStrobe_t stb;
  logic       wpBit;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .subTick (subTick),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .wpBit   (wpBit),
    .stb     (stb)
  );

  rtc_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wpBit  (wpBit)
  );
endmodule

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       subTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bcd_rtc_core #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .subTick(subTick), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expectReg(input string req, input logic [2:0] a, input logic [7:0] exp);
    rdAddr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s addr %0d actual %02h expected %02h", req, a, rdData, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); subTick = 1'b1;
      @(negedge clk); subTick = 1'b0;
    end
  endtask

  task automatic preload(input logic [7:0] hr, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] yr, input logic [7:0] dw);
    writeReg(3'd1, 8'h59);
    writeReg(3'd2, hr);
    writeReg(3'd6, yr);
    writeReg(3'd4, mo);
    writeReg(3'd3, dt);
    writeReg(3'd5, dw);
    writeReg(3'd0, 8'h59);
  endtask

  task automatic testReset;
    expectReg("R1", 3'd0, 8'h00); expectReg("R1", 3'd1, 8'h00);
    expectReg("R1", 3'd2, 8'h00); expectReg("R1", 3'd3, 8'h01);
    expectReg("R1", 3'd4, 8'h01); expectReg("R1", 3'd5, 8'h01);
    expectReg("R1", 3'd6, 8'h00); expectReg("R1", 3'd7, 8'h00);
  endtask

  task automatic testMasks;
    writeReg(3'd5, 8'hFB);
    expectReg("R2 dow mask", 3'd5, 8'h03);
    writeReg(3'd3, 8'hD5);
    expectReg("R2 date mask", 3'd3, 8'h15);
    writeReg(3'd7, 8'h7F);
    expectReg("R2 ctrl mask", 3'd7, 8'h00);
  endtask

  task automatic testFullRollover;
    preload(8'h23, 8'h31, 8'h12, 8'h99, 8'h07);
    pulses(TPS - 1);
    expectReg("R9 no early step", 3'd0, 8'h59);
    pulses(1);
    expectReg("R3 sec", 3'd0, 8'h00); expectReg("R3 min", 3'd1, 8'h00);
    expectReg("R3 hour", 3'd2, 8'h00); expectReg("R6 date", 3'd3, 8'h01);
    expectReg("R7 month", 3'd4, 8'h01); expectReg("R7 year", 3'd6, 8'h00);
    expectReg("R8 dow wrap", 3'd5, 8'h01);
  endtask

  task automatic testMonths;
    preload(8'h23, 8'h28, 8'h02, 8'h24, 8'h02);
    pulses(TPS);
    expectReg("R6 leap feb 29", 3'd3, 8'h29);
    expectReg("R8 dow step", 3'd5, 8'h03);
    preload(8'h23, 8'h29, 8'h02, 8'h24, 8'h03);
    pulses(TPS);
    expectReg("R6 leap end", 3'd3, 8'h01); expectReg("R6 leap month", 3'd4, 8'h03);
    preload(8'h23, 8'h28, 8'h02, 8'h23, 8'h03);
    pulses(TPS);
    expectReg("R6 common feb", 3'd3, 8'h01); expectReg("R6 common month", 3'd4, 8'h03);
    preload(8'h23, 8'h30, 8'h04, 8'h23, 8'h03);
    pulses(TPS);
    expectReg("R6 april end", 3'd3, 8'h01); expectReg("R6 may", 3'd4, 8'h05);
    preload(8'h23, 8'h30, 8'h05, 8'h23, 8'h03);
    pulses(TPS);
    expectReg("R6 may 31", 3'd3, 8'h31); expectReg("R6 may holds", 3'd4, 8'h05);
  endtask

  task automatic testTwelveHour;
    preload(8'h91, 8'h10, 8'h06, 8'h30, 8'h02);
    pulses(TPS);
    expectReg("R4 noon", 3'd2, 8'hB2);
    expectReg("R4 no day step", 3'd3, 8'h10);
    preload(8'hB1, 8'h05, 8'h06, 8'h30, 8'h03);
    pulses(TPS);
    expectReg("R4 midnight", 3'd2, 8'h92);
    expectReg("R4 day step", 3'd3, 8'h06);
    expectReg("R8 dow with 12h", 3'd5, 8'h04);
    preload(8'h92, 8'h06, 8'h06, 8'h30, 8'h04);
    pulses(TPS);
    expectReg("R4 twelve to one", 3'd2, 8'h81);
  endtask

  task automatic testProtect;
    writeReg(3'd1, 8'h12);
    writeReg(3'd7, 8'h80);
    expectReg("R5 wp set", 3'd7, 8'h80);
    writeReg(3'd1, 8'h33);
    expectReg("R5 min blocked", 3'd1, 8'h12);
    writeReg(3'd6, 8'h77);
    expectReg("R5 year blocked", 3'd6, 8'h30);
    writeReg(3'd7, 8'h00);
    writeReg(3'd1, 8'h33);
    expectReg("R5 min after clear", 3'd1, 8'h33);
  endtask

  task automatic testSubSecond;
    writeReg(3'd0, 8'h10);
    pulses(TPS - 1);
    writeReg(3'd0, 8'h20);
    pulses(TPS - 1);
    expectReg("R9 divider cleared", 3'd0, 8'h20);
    pulses(1);
    expectReg("R9 full second", 3'd0, 8'h21);
    writeReg(3'd1, 8'h05);
    pulses(TPS - 1);
    @(negedge clk);
    subTick = 1'b1; wrEn = 1'b1; wrAddr = 3'd1; wrData = 8'h40;
    @(negedge clk);
    subTick = 1'b0; wrEn = 1'b0;
    expectReg("R10 sec steps", 3'd0, 8'h22);
    expectReg("R10 write wins", 3'd1, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testMasks();
    testFullRollover();
    testMonths();
    testTwelveHour();
    testProtect();
    testSubSecond();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule